// File: doc/BRIEF.md
# Bus Wait-State Generator

This block slows down only those CPU bus cycles that target a slow memory region, for example a non-volatile program store. An upstream address decoder supplies an active-low select for the slow device. When that select appears, the block drops the CPU ready line within the same cycle, with no earlier warning needed. The CPU then repeats its current bus cycle in full once for each wait state. Each wait state therefore adds exactly one clock period. All other accesses, such as fast RAM, stack, zero page and I/O, finish in a single cycle with ready held high.

The number of wait states comes from a small input and is sampled at the first cycle of each slow access. A value of 1 to 3 gives that many stalled cycles plus one final cycle in which the access completes. A value of 0 turns stretching off. The block also drives the enable of the latch that holds the multiplexed upper address byte. That enable is active only in cycles where ready is high, so the latch never captures data or stale bus values while the CPU is stalled. Timing is counted in clock cycles and is locked to the CPU clock.

A three-state machine controls the sequence. The states are `WS_IDLE` (no stall in progress), `WS_WAIT` (a stall cycle after the first one) and `WS_LAST` (the completing cycle, ready high). The transitions are:
- `WS_IDLE` goes to `WS_WAIT` on a slow select with a count of 2 or 3.
- `WS_IDLE` goes to `WS_LAST` on a slow select with a count of 1.
- `WS_WAIT` goes to `WS_LAST` when the remaining count reaches one.
- `WS_WAIT` goes to `WS_IDLE` if the select drops early.
- `WS_LAST` always goes to `WS_IDLE`.

The cycle after `WS_LAST` is a new bus cycle. If the select is still asserted then, a fresh stall begins.

Top module: `wait_state_gen`

## Requirements
- R1: While `slow_sel_n` is high (a fast access), `cpu_ready` is high in that same cycle.
- R2: In the first cycle of a slow access with `wait_cnt` nonzero, `cpu_ready` is low in that same cycle. It is driven combinationally from `slow_sel_n`.
- R3: With `wait_cnt` = N (N in 1..3) and `slow_sel_n` held low, `cpu_ready` is low for exactly N consecutive cycles and then high for one cycle, for N+1 cycles in total.
- R4: With `wait_cnt` = 0 at the first cycle of a slow access, `cpu_ready` stays high.
- R5: `addr_latch_en` is high exactly in the cycles where `cpu_ready` is high.
- R6: `wait_cnt` is sampled only at the first cycle of a slow access. Changing it during the stall does not change the length of that access.
- R7: If `slow_sel_n` stays low after the completing cycle, the next cycle starts a new access that stalls for N cycles again. Accesses never merge into an unbounded stall, and no run of low `cpu_ready` is longer than 3 cycles.
- R8: If `slow_sel_n` rises during a stall, `cpu_ready` is high in that cycle. The block returns to idle, so a later select starts a full new stall.
- R9: While `rst_n` is low (a synchronous reset), `cpu_ready` is high. After release the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, same as the CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_sel_n | input | 1 | Decoded slow-device select, active low |
| wait_cnt | input | 2 | Number of wait states, 0 to 3 |
| cpu_ready | output | 1 | Ready to the CPU, low stalls the bus cycle |
| addr_latch_en | output | 1 | Enable for the upper-address-byte latch |

## Verification
The bench covers every wait count from 0 to 3 against select pulses of 1 to 9 cycles. This covers the following cases:
- A select that drops in the middle of a stall. A design that kept counting would hold ready low into a fast cycle.
- A select held across several accesses. A design that never re-armed would let later slow cycles through unstretched, and one that never released would stall forever.
- The first cycle of each access. A registered ready would be one cycle late there and let the device be read too early.

Separate cases change the wait count mid-stall, where a design that re-read the input would shorten or lengthen the access. They also hold reset with the select asserted, where ready must stay high.

// File: rtl/ws_pkg.sv
package ws_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_WAIT = 2'd1,
        WS_LAST = 2'd2
    } ws_state_e;

endpackage

// File: rtl/ws_down_counter.sv
module ws_down_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && count_q != '0) begin
            count_q <= count_q - ONE;
        end
    end

    assign is_one = (count_q == ONE);
endmodule

// File: rtl/ws_fsm.sv
module ws_fsm
    import ws_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_act,
    input  logic [CNT_W-1:0] wait_req,
    input  logic             cnt_is_one,
    output ws_state_e        state,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             dec
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ws_state_e state_q;
    ws_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        dec      = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (sel_act && wait_req != '0) begin
                    load     = 1'b1;
                    load_val = wait_req - ONE;
                    state_d  = (wait_req == ONE) ? WS_LAST : WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (!sel_act) begin
                    state_d = WS_IDLE;
                end else begin
                    dec = 1'b1;
                    if (cnt_is_one) begin
                        state_d = WS_LAST;
                    end
                end
            end
            WS_LAST: begin
                state_d = WS_IDLE;
            end
            default: begin
                state_d = WS_IDLE;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ws_ready_out.sv
module ws_ready_out
    import ws_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             rst_n,
    input  ws_state_e        state,
    input  logic             sel_act,
    input  logic [CNT_W-1:0] wait_req,
    output logic             cpu_ready,
    output logic             addr_latch_en
);
    logic stall;

    always_comb begin
        stall = 1'b0;
        unique case (state)
            WS_IDLE: stall = sel_act && (wait_req != '0);
            WS_WAIT: stall = sel_act;
            WS_LAST: stall = 1'b0;
            default: stall = 1'b0;
        endcase
        if (!rst_n) begin
            stall = 1'b0;
        end
    end

    assign cpu_ready     = !stall;
    assign addr_latch_en = !stall;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
    import ws_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_sel_n,
    input  logic [CNT_W-1:0] wait_cnt,
    output logic             cpu_ready,
    output logic             addr_latch_en
);
    logic             sel_act;
    logic             cnt_is_one;
    logic             load;
    logic             dec;
    logic [CNT_W-1:0] load_val;
    ws_state_e        state;

    assign sel_act = !slow_sel_n;

    ws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_act    (sel_act),
        .wait_req   (wait_cnt),
        .cnt_is_one (cnt_is_one),
        .state      (state),
        .load       (load),
        .load_val   (load_val),
        .dec        (dec)
    );

    ws_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .is_one   (cnt_is_one)
    );

    ws_ready_out #(.CNT_W(CNT_W)) u_out (
        .rst_n         (rst_n),
        .state         (state),
        .sel_act       (sel_act),
        .wait_req      (wait_cnt),
        .cpu_ready     (cpu_ready),
        .addr_latch_en (addr_latch_en)
    );
endmodule

// File: rtl/wait_state_gen_checker.sv
module wait_state_gen_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_sel_n,
    input logic [CNT_W-1:0] wait_cnt,
    input logic             cpu_ready,
    input logic             addr_latch_en
);
    localparam int MAX_LOW = (1 << CNT_W) - 1;

    logic   past_ok;
    integer low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            low_run <= 0;
        end else begin
            past_ok <= 1'b1;
            low_run <= cpu_ready ? 0 : low_run + 1;
        end
    end

    AST_FAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        slow_sel_n |-> cpu_ready); // R1

    AST_FIRST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cpu_ready) && !slow_sel_n && wait_cnt != '0) |-> !cpu_ready); // R2

    AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cpu_ready) && !slow_sel_n && wait_cnt == '0) |-> cpu_ready); // R4

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= MAX_LOW); // R7

    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_en == cpu_ready); // R5

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_READY: assert (cpu_ready); // R9
        end
    end
endmodule

bind wait_state_gen wait_state_gen_checker #(.CNT_W(CNT_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .slow_sel_n    (slow_sel_n),
    .wait_cnt      (wait_cnt),
    .cpu_ready     (cpu_ready),
    .addr_latch_en (addr_latch_en)
);

// File: tb/wait_state_gen_bench.sv
`timescale 1ns/1ps
module wait_state_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_sel_n = 1'b1;
    logic [1:0] wait_cnt = 2'd0;
    logic       cpu_ready;
    logic       addr_latch_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wait_state_gen u_wait_state_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .slow_sel_n    (slow_sel_n),
        .wait_cnt      (wait_cnt),
        .cpu_ready     (cpu_ready),
        .addr_latch_en (addr_latch_en)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_ready(input int n, input int i);
        if (n == 0) return 1'b1;
        return ((i % (n + 1)) == n);
    endfunction

    task automatic step_check(input string tag, input logic exp);
        #1;
        check(tag, cpu_ready, exp);
        check("R5", addr_latch_en, exp);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        slow_sel_n = 1'b0;
        wait_cnt   = 2'd3;
        #1;
        check("R9", cpu_ready, 1'b1);
        @(negedge clk);
        #1;
        check("R9", cpu_ready, 1'b1);
        slow_sel_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        step_check("R1", 1'b1);
        step_check("R1", 1'b1);

        for (int n = 0; n < 4; n++) begin
            for (int len = 1; len < 10; len++) begin
                wait_cnt   = 2'(n);
                slow_sel_n = 1'b0;
                for (int i = 0; i < len; i++) begin
                    string tag;
                    if (i == 0) tag = (n == 0) ? "R4" : "R2";
                    else if (i > n) tag = "R7";
                    else tag = "R3";
                    step_check(tag, exp_ready(n, i));
                end
                slow_sel_n = 1'b1;
                step_check((len % (n + 1)) != 0 ? "R8" : "R1", 1'b1);
                step_check("R1", 1'b1);
            end
        end

        wait_cnt   = 2'd3;
        slow_sel_n = 1'b0;
        step_check("R6", 1'b0);
        wait_cnt = 2'd1;
        step_check("R6", 1'b0);
        wait_cnt = 2'd0;
        step_check("R6", 1'b0);
        step_check("R6", 1'b1);
        slow_sel_n = 1'b1;
        step_check("R1", 1'b1);

        wait_cnt   = 2'd1;
        slow_sel_n = 1'b0;
        step_check("R6", 1'b0);
        wait_cnt = 2'd3;
        step_check("R6", 1'b1);
        slow_sel_n = 1'b1;
        step_check("R1", 1'b1);

        wait_cnt   = 2'd2;
        slow_sel_n = 1'b0;
        step_check("R2", 1'b0);
        rst_n = 1'b0;
        #1;
        check("R9", cpu_ready, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        step_check("R9", 1'b0);
        step_check("R3", 1'b0);
        step_check("R3", 1'b1);
        slow_sel_n = 1'b1;
        step_check("R1", 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule